// File: doc/BRIEF.md
# Two-Stage Nested Page Table Walker

This block converts a guest-physical address into a host-physical address. It walks a four-level radix tree of 64-bit entries held in memory. A 64-bit root pointer names the top-level table and selects whether accessed and dirty flags are tracked. A request gives a 48-bit guest-physical address and an access kind. The walker then reads one entry per level through a single memory port with variable latency. The walk ends at a 4 KB leaf or early at a 1 GB or 2 MB large-page entry. The reply is either the translated address or a violation that names the level where the walk stopped.

At each level the walker checks that the entry is present and that it grants the requested access. When tracking is on, the walker writes back an entry whose flag bits have to change. The write covers that entry only. Flags that are already set are never written again. The walker handles one request at a time. A root pointer that is malformed is rejected at once, with no memory traffic.

Top module: `gpa_walker`

## Requirements
- R1: If root bits 11:7 are not all zero, or root bits 5:3 are not 3, the response has status 2 (configuration error) and level 0. It appears in the first cycle after acceptance, and no memory request is issued.
- R2: Each level reads one 8-byte entry at byte address {table frame, 9-bit index, 3'b000}. The levels run from 4 down to 1, indexed by address bits 47:39, 38:30, 29:21 and 20:12. The level-4 frame is root bits 51:12. Every later frame is bits 51:12 of the entry above.
- R3: A level-1 entry gives status 0, level 0, and address {entry bits 51:12, address bits 11:0}. Entry bits 63:52 do not affect the address.
- R4: A level-3 entry with bit 7 set ends the walk with address {entry bits 51:30, address bits 29:0}. A level-2 entry with bit 7 set ends it with {entry bits 51:21, address bits 20:0}. Bit 7 has no effect at levels 4 and 1.
- R5: An entry with both bit 0 and bit 1 clear stops the walk with status 1 and the level of that entry (4 = top, 1 = last). The address field is then zero. This holds even if bit 2 is set.
- R6: Access code 0 (read) needs entry bit 0, code 1 (write) needs bit 1, and code 2 (fetch) needs bit 2. This applies at every level. If the bit is missing, the walk stops with status 1 and that level.
- R7: When root bit 6 is set, each entry that passes its checks and has bit 8 clear is written back to the same address with bit 8 set. No write is made when nothing changes, and an entry that causes a violation is never written.
- R8: With root bit 6 set and a write access, the leaf entry also gets bit 9 set. The leaf is the level-1 entry or a large-page entry. Non-leaf entries and non-write accesses never cause bit 9 to be set.
- R9: With root bit 6 clear, the walker issues no memory writes.
- R10: req_ready is low from acceptance until the response handshake. The response fields hold steady while rsp_valid is high and rsp_ready is low.
- R11: A memory request holds its address, direction and data until mem_req_ready. Each read waits for its mem_rsp_valid before the walk moves on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| root_ptr | input | 64 | Root pointer, sampled at request acceptance |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_gpa | input | 48 | Guest-physical address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 for an entry writeback, 0 for a read |
| mem_req_addr | output | 52 | Byte address of the entry |
| mem_req_wdata | output | 64 | Entry value to write |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | 64 | Read data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_status | output | 2 | 0 translated, 1 violation, 2 configuration error |
| rsp_hpa | output | 52 | Host-physical address (zero unless status 0) |
| rsp_level | output | 3 | Level where a violation occurred, else 0 |

## Verification
A configuration error appears on the first cycle after the accepting edge, so the bench checks rsp_valid at the very next falling edge. A walk needs a handshake on every read and writeback, and the memory model varies both its acceptance and its data delay. For that reason the bench does not count a fixed number of cycles. It waits on rsp_valid at falling edges and checks the reply fields there. It also counts the reads and writes the model saw between acceptance and the response handshake, and compares them with the expected walk depth. Flag writebacks are checked in the model's memory after the handshake, when the walker is idle again.

// File: rtl/walk_pkg.sv
// Package: widths, field positions and codes shared by the walker and its bench.
// Assumes 64-bit entries, 4 KB tables of 512 entries and a four-level tree.
package walk_pkg;
    parameter int GPA_W = 48;                    // guest-physical address width
    parameter int HPA_W = 52;                    // host-physical address width
    parameter int ENT_W = 64;                    // entry width in bits
    parameter int IDX_W = 9;                     // index bits per level
    parameter int LVLS  = 4;                     // levels in a full walk

    localparam int ENT_SH = $clog2(ENT_W / 8);   // byte offset bits of an entry
    localparam int OFS_W  = IDX_W + ENT_SH;      // page offset bits (12)
    localparam int FRM_W  = HPA_W - OFS_W;       // frame number width
    localparam int LVL_W  = $clog2(LVLS + 1);    // width holding 0..LVLS
    localparam int LARGE_LO = 2;                 // lowest level allowed to map a large page
    localparam int LARGE_HI = 3;                 // highest level allowed to map a large page

    localparam int BIT_R     = 0;
    localparam int BIT_W     = 1;
    localparam int BIT_X     = 2;
    localparam int BIT_LARGE = 7;
    localparam int BIT_ACC   = 8;
    localparam int BIT_DIRTY = 9;
    localparam int ROOT_AD   = 6;

    localparam logic [1:0] ACC_READ  = 2'd0;
    localparam logic [1:0] ACC_WRITE = 2'd1;
    localparam logic [1:0] ACC_FETCH = 2'd2;

    localparam logic [1:0] ST_OK   = 2'd0;
    localparam logic [1:0] ST_VIOL = 2'd1;
    localparam logic [1:0] ST_CFG  = 2'd2;

    typedef enum logic [2:0] {
        S_IDLE, S_RD_REQ, S_RD_WAIT, S_WR_REQ, S_RESP
    } walk_state_e;
endpackage

// File: rtl/walk_addr_gen.sv
// Module: forms the byte address of the entry used at the current level.
// Assumes level is in 1..LVLS; level LVLS uses the highest index field.
module walk_addr_gen
    import walk_pkg::*;
(
    input  logic [FRM_W-1:0] table_frame,
    input  logic [LVL_W-1:0] level,
    input  logic [GPA_W-1:0] gpa,
    output logic [HPA_W-1:0] entry_addr
);
    logic [IDX_W-1:0] idx_by_lvl [LVLS];
    logic [IDX_W-1:0] idx_sel;
    wire  unused_gpa_low = ^gpa[OFS_W-1:0];

    // Slice one index field per level.
    for (genvar g = 0; g < LVLS; g++) begin : g_idx
        assign idx_by_lvl[g] = gpa[OFS_W + g*IDX_W +: IDX_W];
    end

    // Pick the field for the current level and append the entry offset.
    always_comb begin
        idx_sel = '0;
        for (int i = 0; i < LVLS; i++) begin
            if (level == LVL_W'(i + 1)) idx_sel = idx_by_lvl[i];
        end
        entry_addr = {table_frame, idx_sel, {ENT_SH{1'b0}}};
    end
endmodule

// File: rtl/walk_entry_eval.sv
// Module: judges one fetched entry. It checks presence and permission,
// detects a leaf, computes the flag update and the final address.
// Assumes level is in 1..LVLS; the result is meaningful only when data is valid.
module walk_entry_eval
    import walk_pkg::*;
(
    input  logic [ENT_W-1:0] entry,
    input  logic [LVL_W-1:0] level,
    input  logic [1:0]       acc,
    input  logic             ad_en,
    input  logic [GPA_W-1:0] gpa,
    output logic             viol,
    output logic             leaf,
    output logic             need_wr,
    output logic [ENT_W-1:0] upd_entry,
    output logic [FRM_W-1:0] next_frame,
    output logic [HPA_W-1:0] hpa
);
    logic             present;
    logic             allowed;
    logic [ENT_W-1:0] set_bits;
    logic [HPA_W-1:0] low_mask;
    int               span;

    // Presence and permission for the requested access kind.
    always_comb begin
        present = entry[BIT_R] | entry[BIT_W];
        case (acc)
            ACC_WRITE: allowed = entry[BIT_W];
            ACC_FETCH: allowed = entry[BIT_X];
            default:   allowed = entry[BIT_R];
        endcase
        viol = !present || !allowed;
    end

    // Leaf detection: last level, or a large-page entry at a level that allows one.
    always_comb begin
        leaf = (level == LVL_W'(1)) ||
               (entry[BIT_LARGE] && level >= LVL_W'(LARGE_LO) && level <= LVL_W'(LARGE_HI));
    end

    // Sticky flag update; a write is needed only when a bit actually changes.
    always_comb begin
        set_bits = '0;
        if (ad_en) begin
            set_bits[BIT_ACC] = 1'b1;
            if (leaf && acc == ACC_WRITE) set_bits[BIT_DIRTY] = 1'b1;
        end
        upd_entry = entry | set_bits;
        need_wr   = ad_en && !viol && (upd_entry != entry);
    end

    // Final address: entry frame above the page span, request bits below it.
    always_comb begin
        span = OFS_W;
        for (int i = 0; i < LVLS; i++) begin
            if (level == LVL_W'(i + 1)) span = OFS_W + i * IDX_W;
        end
        low_mask   = (HPA_W'(1) << span) - HPA_W'(1);
        hpa        = (entry[HPA_W-1:0] & ~low_mask) |
                     ({{(HPA_W-GPA_W){1'b0}}, gpa} & low_mask);
        next_frame = entry[HPA_W-1:OFS_W];
    end
endmodule

// File: rtl/gpa_walker.sv
// Module: top of the nested table walker. It accepts one request, walks the
// levels through one memory port, writes back changed flag bits, and holds
// the response until it is taken.
// Assumes the memory returns exactly one mem_rsp_valid per accepted read and
// none for writes (a write is complete when accepted).
module gpa_walker
    import walk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [63:0]      root_ptr,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [GPA_W-1:0] req_gpa,
    input  logic [1:0]       req_acc,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic             mem_req_we,
    output logic [HPA_W-1:0] mem_req_addr,
    output logic [ENT_W-1:0] mem_req_wdata,
    input  logic             mem_rsp_valid,
    input  logic [ENT_W-1:0] mem_rsp_rdata,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [1:0]       rsp_status,
    output logic [HPA_W-1:0] rsp_hpa,
    output logic [2:0]       rsp_level
);
    walk_state_e      state;
    logic [GPA_W-1:0] gpa_q;
    logic [1:0]       acc_q;
    logic             ad_en_q;
    logic [LVL_W-1:0] level_q;
    logic [FRM_W-1:0] frame_q;
    logic [ENT_W-1:0] ent_q;
    logic             leaf_q;
    logic [1:0]       st_q;
    logic [HPA_W-1:0] hpa_q;
    logic [LVL_W-1:0] lvl_q;

    logic             cfg_bad;
    logic [HPA_W-1:0] entry_addr;
    logic             e_viol, e_leaf, e_need_wr;
    logic [ENT_W-1:0] e_upd;
    logic [FRM_W-1:0] e_next;
    logic [HPA_W-1:0] e_hpa;
    wire              unused_root = ^{root_ptr[63:HPA_W], root_ptr[2:0]};

    // Root pointer sanity: reserved field clear, walk length matches the tree.
    assign cfg_bad = (|root_ptr[11:7]) || (root_ptr[5:3] != 3'(LVLS - 1));

    walk_addr_gen u_addr (
        .table_frame (frame_q),
        .level       (level_q),
        .gpa         (gpa_q),
        .entry_addr  (entry_addr)
    );

    walk_entry_eval u_eval (
        .entry      (mem_rsp_rdata),
        .level      (level_q),
        .acc        (acc_q),
        .ad_en      (ad_en_q),
        .gpa        (gpa_q),
        .viol       (e_viol),
        .leaf       (e_leaf),
        .need_wr    (e_need_wr),
        .upd_entry  (e_upd),
        .next_frame (e_next),
        .hpa        (e_hpa)
    );

    // Port outputs decoded from the walk state and held registers.
    assign req_ready     = (state == S_IDLE);
    assign mem_req_valid = (state == S_RD_REQ) || (state == S_WR_REQ);
    assign mem_req_we    = (state == S_WR_REQ);
    assign mem_req_addr  = entry_addr;
    assign mem_req_wdata = ent_q;
    assign rsp_valid     = (state == S_RESP);
    assign rsp_status    = st_q;
    assign rsp_hpa       = hpa_q;
    assign rsp_level     = 3'(lvl_q);

    // Walk sequencer: accept, read per level, optional writeback, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            gpa_q   <= '0;
            acc_q   <= ACC_READ;
            ad_en_q <= 1'b0;
            level_q <= '0;
            frame_q <= '0;
            ent_q   <= '0;
            leaf_q  <= 1'b0;
            st_q    <= ST_OK;
            hpa_q   <= '0;
            lvl_q   <= '0;
        end else begin
            case (state)
                S_IDLE: if (req_valid) begin
                    gpa_q   <= req_gpa;
                    acc_q   <= req_acc;
                    ad_en_q <= root_ptr[ROOT_AD];
                    frame_q <= root_ptr[HPA_W-1:OFS_W];
                    level_q <= LVL_W'(LVLS);
                    hpa_q   <= '0;
                    lvl_q   <= '0;
                    if (cfg_bad) begin
                        st_q  <= ST_CFG;
                        state <= S_RESP;
                    end else begin
                        st_q  <= ST_OK;
                        state <= S_RD_REQ;
                    end
                end
                S_RD_REQ: if (mem_req_ready) state <= S_RD_WAIT;
                S_RD_WAIT: if (mem_rsp_valid) begin
                    ent_q  <= e_upd;
                    leaf_q <= e_leaf;
                    hpa_q  <= e_hpa;
                    if (e_viol) begin
                        st_q  <= ST_VIOL;
                        lvl_q <= level_q;
                        hpa_q <= '0;
                        state <= S_RESP;
                    end else if (e_need_wr) begin
                        state <= S_WR_REQ;
                    end else if (e_leaf) begin
                        state <= S_RESP;
                    end else begin
                        frame_q <= e_next;
                        level_q <= level_q - LVL_W'(1);
                        state   <= S_RD_REQ;
                    end
                end
                S_WR_REQ: if (mem_req_ready) begin
                    if (leaf_q) begin
                        state <= S_RESP;
                    end else begin
                        frame_q <= ent_q[HPA_W-1:OFS_W];
                        level_q <= level_q - LVL_W'(1);
                        state   <= S_RD_REQ;
                    end
                end
                S_RESP: if (rsp_ready) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/gpa_walker_chk.sv
// Module: property checker for gpa_walker, attached by bind.
// Assumes it sees the walker's ports plus its latched tracking enable.
module gpa_walker_chk
    import walk_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [63:0]      root_ptr,
    input logic             req_valid,
    input logic             req_ready,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic             mem_req_we,
    input logic [HPA_W-1:0] mem_req_addr,
    input logic [ENT_W-1:0] mem_req_wdata,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic [1:0]       rsp_status,
    input logic [HPA_W-1:0] rsp_hpa,
    input logic [2:0]       rsp_level,
    input logic             ad_en
);
    logic root_bad;
    assign root_bad = (|root_ptr[11:7]) || (root_ptr[5:3] != 3'(LVLS - 1));

    p_cfg_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && root_bad) |=>
            (rsp_valid && rsp_status == ST_CFG && rsp_level == 3'd0 && !mem_req_valid));

    p_addr_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[ENT_SH-1:0] == '0));

    p_ok_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == ST_OK) |-> (rsp_level == 3'd0));

    p_viol_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == ST_VIOL) |->
            (rsp_level >= 3'd1 && rsp_level <= 3'(LVLS) && rsp_hpa == '0));

    p_acc_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we) |-> mem_req_wdata[BIT_ACC]);

    p_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we) |-> ad_en);

    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_status) && $stable(rsp_hpa) && $stable(rsp_level)));

    p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)
             && $stable(mem_req_wdata)));
endmodule

bind gpa_walker gpa_walker_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .root_ptr      (root_ptr),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_status    (rsp_status),
    .rsp_hpa       (rsp_hpa),
    .rsp_level     (rsp_level),
    .ad_en         (ad_en_q)
);

// File: tb/tb_gpa_walker.sv
// Bench: vector table of walks over a fixed tree, then directed tests.
module tb_gpa_walker;
    import walk_pkg::*;

    localparam int CLK_P = 10;
    localparam logic [63:0] ROOT_PLAIN = 64'h0000_0000_0010_001E; // frame 0x100, len 3, WB
    localparam logic [63:0] ROOT_AD    = 64'h0000_0000_0010_005E; // same, tracking on

    typedef struct packed {
        logic [47:0] gpa;
        logic [1:0]  acc;
        logic [1:0]  st;
        logic [51:0] hpa;
        logic [2:0]  lvl;
        logic [3:0]  nrd;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{48'h0000_0000_0123, 2'd0, 2'd0, 52'h0_0000_ABCD_E123, 3'd0, 4'd4}, // R3 4K read
        '{48'h0000_4ABC_DEF0, 2'd1, 2'd0, 52'h0_00C0_0ABC_DEF0, 3'd0, 4'd2}, // R4 1G write
        '{48'h0000_0021_2345, 2'd2, 2'd0, 52'h0_0008_0061_2345, 3'd0, 4'd3}, // R4 2M fetch
        '{48'h0000_0040_0ABC, 2'd2, 2'd1, 52'h0,                3'd2, 4'd3}, // R6 no exec L2
        '{48'h0000_0040_0ABC, 2'd0, 2'd0, 52'h0_0008_00A0_0ABC, 3'd0, 4'd3}, // R6 read ok
        '{48'h0000_8000_0010, 2'd1, 2'd1, 52'h0,                3'd3, 4'd2}, // R6 ro table L3
        '{48'h0000_8000_0010, 2'd0, 2'd0, 52'h0_0000_ABCD_E010, 3'd0, 4'd4}, // R6 read through
        '{48'h0000_C000_0000, 2'd2, 2'd1, 52'h0,                3'd3, 4'd2}, // R5 exec-only L3
        '{48'h0080_0000_0000, 2'd0, 2'd1, 52'h0,                3'd4, 4'd1}, // R5 empty L4
        '{48'h0000_0000_1044, 2'd1, 2'd1, 52'h0,                3'd1, 4'd4}, // R6 ro leaf
        '{48'h0000_0000_1FFF, 2'd0, 2'd0, 52'h0_0000_1111_1FFF, 3'd0, 4'd4}, // R3 ro leaf read
        '{48'h0000_0000_507A, 2'd2, 2'd0, 52'h0_0000_2222_307A, 3'd0, 4'd4}, // R3 R4 bit7 at L1
        '{48'h0100_0000_0000, 2'd0, 2'd0, 52'h0_0000_ABCD_E000, 3'd0, 4'd4}  // R4 bit7 at L4
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [63:0]      root_ptr = '0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [47:0]      req_gpa = '0;
    logic [1:0]       req_acc = '0;
    logic             mem_req_valid, mem_req_ready, mem_req_we;
    logic [51:0]      mem_req_addr;
    logic [63:0]      mem_req_wdata;
    logic             mem_rsp_valid = 1'b0;
    logic [63:0]      mem_rsp_rdata = '0;
    logic             rsp_valid;
    logic             rsp_ready = 1'b0;
    logic [1:0]       rsp_status;
    logic [51:0]      rsp_hpa;
    logic [2:0]       rsp_level;

    int errors = 0;
    int checks = 0;

    // Memory model state.
    logic [63:0] mem [logic [51:0]];
    logic [51:0] rd_hist [256];
    int          n_rd = 0;
    int          n_wr = 0;
    logic [3:0]  stall_q = '0;
    logic        pend = 1'b0;
    logic [63:0] pend_data = '0;
    logic [1:0]  lat = '0;

    // Results of the last walk.
    logic [1:0]  got_st;
    logic [51:0] got_hpa;
    logic [2:0]  got_lvl;
    int          got_rd, got_wr, rd_base, wait_cyc;
    logic        leak;

    always #(CLK_P/2) clk = ~clk;

    gpa_walker dut (
        .clk(clk), .rst_n(rst_n), .root_ptr(root_ptr),
        .req_valid(req_valid), .req_ready(req_ready), .req_gpa(req_gpa), .req_acc(req_acc),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
        .rsp_hpa(rsp_hpa), .rsp_level(rsp_level)
    );

    function automatic logic [63:0] mem_rd(input logic [51:0] a);
        return mem.exists(a) ? mem[a] : 64'h0;
    endfunction

    // Memory model: accepts on 3 of 4 cycles, returns reads after 1 to 4 cycles.
    assign mem_req_ready = stall_q[0] | stall_q[1];
    always @(posedge clk) begin
        stall_q       <= stall_q + 4'd1;
        mem_rsp_valid <= 1'b0;
        if (pend) begin
            if (lat == 2'd0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= pend_data;
                pend          <= 1'b0;
            end else begin
                lat <= lat - 2'd1;
            end
        end
        if (rst_n && mem_req_valid && mem_req_ready) begin
            if (mem_req_we) begin
                mem[mem_req_addr] = mem_req_wdata;
                n_wr <= n_wr + 1;
            end else begin
                pend                <= 1'b1;
                pend_data           <= mem_rd(mem_req_addr);
                lat                 <= stall_q[3:2];
                rd_hist[n_rd % 256] <= mem_req_addr;
                n_rd                <= n_rd + 1;
            end
        end
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One walk: drive the request, wait for the reply, optionally stall the reply.
    task automatic run_walk(input logic [63:0] root, input logic [47:0] gpa,
                            input logic [1:0] acc, input int hold);
        int wr0;
        @(negedge clk);
        root_ptr  = root;
        req_gpa   = gpa;
        req_acc   = acc;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        rd_base = n_rd;
        wr0     = n_wr;
        @(negedge clk);
        req_valid = 1'b0;
        wait_cyc  = 0;
        leak      = 1'b0;
        while (!rsp_valid) begin
            if (req_ready) leak = 1'b1;
            @(negedge clk);
            wait_cyc++;
        end
        got_st  = rsp_status;
        got_hpa = rsp_hpa;
        got_lvl = rsp_level;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (!rsp_valid || req_ready || rsp_hpa !== got_hpa || rsp_status !== got_st)
                leak = 1'b1;
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        got_rd = n_rd - rd_base;
        got_wr = n_wr - wr0;
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        checks++;
        $display("FAIL R10 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // Tree: L4 table frame 0x100, L3 0x101, L2 0x102, L1 0x103.
        mem[52'h10_0000] = 64'h0000_0000_0010_1007;
        mem[52'h10_0010] = 64'h0000_0000_0010_1087;
        mem[52'h10_1000] = 64'h0000_0000_0010_2007;
        mem[52'h10_1008] = 64'h0000_00C0_0000_0087;
        mem[52'h10_1010] = 64'h0000_0000_0010_2001;
        mem[52'h10_1018] = 64'h0000_0000_0000_0004;
        mem[52'h10_2000] = 64'h0000_0000_0010_3007;
        mem[52'h10_2008] = 64'h0000_0008_0060_0087;
        mem[52'h10_2010] = 64'h0000_0008_00A0_0083;
        mem[52'h10_3000] = 64'h0000_0000_ABCD_E007;
        mem[52'h10_3008] = 64'h0000_0000_1111_1001;
        mem[52'h10_3028] = 64'hFFF0_0000_2222_3087;

        repeat (4) @(negedge clk);
        // Reset state (R10 R11).
        check("R10", "reset req_ready", 64'(req_ready), 64'd1);
        check("R10", "reset rsp_valid", 64'(rsp_valid), 64'd0);
        check("R11", "reset mem_req_valid", 64'(mem_req_valid), 64'd0);
        rst_n = 1'b1;

        // Vector table, tracking off (R3 R4 R5 R6 R9).
        for (int v = 0; v < NV; v++) begin
            run_walk(ROOT_PLAIN, VEC[v].gpa, VEC[v].acc, 0);
            check("R3-R6 status", $sformatf("vec %0d", v), 64'(got_st), 64'(VEC[v].st));
            check("R3-R6 addr",   $sformatf("vec %0d", v), 64'(got_hpa), 64'(VEC[v].hpa));
            check("R5 R6 level",  $sformatf("vec %0d", v), 64'(got_lvl), 64'(VEC[v].lvl));
            check("R2 R4 reads",  $sformatf("vec %0d", v), 64'(got_rd), 64'(VEC[v].nrd));
            check("R9 no writes", $sformatf("vec %0d", v), 64'(got_wr), 64'd0);
        end

        // R2: entry addresses of the walk for 0x507A.
        run_walk(ROOT_PLAIN, 48'h507A, ACC_READ, 0);
        check("R2", "read L4", 64'(rd_hist[(rd_base + 0) % 256]), 64'h10_0000);
        check("R2", "read L3", 64'(rd_hist[(rd_base + 1) % 256]), 64'h10_1000);
        check("R2", "read L2", 64'(rd_hist[(rd_base + 2) % 256]), 64'h10_2000);
        check("R2", "read L1", 64'(rd_hist[(rd_base + 3) % 256]), 64'h10_3028);

        // R1: bad walk length and reserved bit, immediate reply without memory access.
        run_walk(64'h0000_0000_0010_0026, 48'h123, ACC_READ, 0);
        check("R1", "len status", 64'(got_st), 64'(ST_CFG));
        check("R1", "len level", 64'(got_lvl), 64'd0);
        check("R1", "len delay", 64'(wait_cyc), 64'd0);
        check("R1", "len mem reads", 64'(got_rd), 64'd0);
        run_walk(64'h0000_0000_0010_021E, 48'h123, ACC_READ, 0);
        check("R1", "rsvd status", 64'(got_st), 64'(ST_CFG));
        check("R1", "rsvd mem reads", 64'(got_rd), 64'd0);

        // R10: reply held under back-pressure, no new acceptance meanwhile.
        run_walk(ROOT_PLAIN, 48'h123, ACC_READ, 5);
        check("R10", "busy/hold leak", 64'(leak), 64'd0);
        check("R10", "held addr", 64'(got_hpa), 64'h0_ABCD_E123);

        // R7: tracking on, first read marks every entry on the path.
        run_walk(ROOT_AD, 48'h123, ACC_READ, 0);
        check("R7", "status", 64'(got_st), 64'(ST_OK));
        check("R7", "writes", 64'(got_wr), 64'd4);
        check("R7", "L4 entry", mem_rd(52'h10_0000), 64'h0000_0000_0010_1107);
        check("R7", "L1 entry", mem_rd(52'h10_3000), 64'h0000_0000_ABCD_E107);
        run_walk(ROOT_AD, 48'h123, ACC_READ, 0);
        check("R7", "sticky no rewrite", 64'(got_wr), 64'd0);

        // R8: write sets dirty on the leaf only, once.
        run_walk(ROOT_AD, 48'h123, ACC_WRITE, 0);
        check("R8", "writes", 64'(got_wr), 64'd1);
        check("R8", "leaf dirty", mem_rd(52'h10_3000), 64'h0000_0000_ABCD_E307);
        check("R8", "L2 not dirty", mem_rd(52'h10_2000), 64'h0000_0000_0010_3107);
        run_walk(ROOT_AD, 48'h123, ACC_WRITE, 0);
        check("R8", "repeat writes", 64'(got_wr), 64'd0);
        run_walk(ROOT_AD, 48'h21_2345, ACC_WRITE, 0);
        check("R8", "2M writes", 64'(got_wr), 64'd1);
        check("R8", "2M leaf", mem_rd(52'h10_2008), 64'h0000_0008_0060_0387);
        check("R8", "2M addr", 64'(got_hpa), 64'h0_0008_0061_2345);

        // R7: a violating entry is left untouched.
        run_walk(ROOT_AD, 48'h1044, ACC_WRITE, 0);
        check("R7", "viol status", 64'(got_st), 64'(ST_VIOL));
        check("R7", "viol writes", 64'(got_wr), 64'd0);
        check("R7", "viol entry", mem_rd(52'h10_3008), 64'h0000_0000_1111_1001);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule